// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between a bank of peripheral interrupt lines and the CPU. Every line arrives already gated by its own peripheral's enable. The block picks one pending line and offers it to the CPU as a request, a vector number, a level flag and a vector address.

There are two priority levels. A single vector, chosen by a software-written number, is raised to the high level. All other lines share the normal level. Among normal lines the winner is either the lowest number (fixed order) or the next number after the last one serviced (rotating order).

The block keeps one "in service" bit per level. An acknowledge pulse from the CPU sets the bit of the level it granted, and a return pulse clears the bit of the highest level in service. Acknowledge never clears the pending state: a line stays pending until software clears it at its source. A wake output tells the sleep logic that an enabled line is pending.

Top module: `dual_level_intc`

## Requirements
- R1: When `gie` is 0, `req` is 0 whatever the lines and state are.
- R2: When line `hi_vec` is pending and the high level is not in service, the block offers that vector with `req_hi`=1, ahead of any normal line.
- R3: With `rr_en`=0, the lowest-numbered pending normal line (every line except `hi_vec`) is offered.
- R4: With `rr_en`=1, the search starts one past the last acknowledged normal vector and wraps modulo the vector count. After reset the search starts at vector 0. Acknowledging a high-level vector does not move the start point.
- R5: An `ack` while `req`=1 sets `in_service[0]` for a normal grant or `in_service[1]` for a high grant. An `ack` while `req`=0 changes nothing.
- R6: While `in_service[1]`=1 nothing is offered. While only `in_service[0]`=1, only the high-level vector may be offered.
- R7: A `reti` pulse clears `in_service[1]` if it is set, and otherwise clears `in_service[0]`.
- R8: Acknowledging does not clear pending state. After the return, a line that is still high is offered again.
- R9: With `compact`=0, `req_addr` = base + 2 × `req_vec`. The base is `BASE_MAIN` when `alt_base`=0 and `BASE_ALT` when `alt_base`=1 (defaults 0x0000 and 0x0200).
- R10: With `compact`=1, `req_addr` is base + 2 for the high-level vector and base + 4 for any normal vector.
- R11: `wake` equals `gie` AND (any line pending), independent of the in-service bits.
- R12: After reset, `in_service` is 0 and `req` is 0 while no line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_VEC | Pending lines, already enabled at their peripherals |
| gie | input | 1 | Global interrupt enable |
| rr_en | input | 1 | 1 selects rotating order at the normal level |
| alt_base | input | 1 | Selects the alternate vector base |
| compact | input | 1 | Compact vector table mode |
| hi_vec | input | VW | Number of the vector raised to high level |
| ack | input | 1 | CPU acknowledge pulse |
| reti | input | 1 | CPU return-from-interrupt pulse |
| req | output | 1 | Request to the CPU |
| req_hi | output | 1 | Offered request is high level |
| req_vec | output | VW | Offered vector number |
| req_addr | output | AW | Offered vector address |
| in_service | output | 2 | In-service bits: [0] normal, [1] high |
| wake | output | 1 | Wake-up to the sleep controller |

## Verification
The bench sweeps every line pattern against every choice of high vector, both bases and both table modes, with the global enable both on and off. This catches a picker that lets the high vector compete at the normal level, takes the highest instead of the lowest number, or forms addresses from the wrong base or slot.

Rotating order is driven through acknowledge and return cycles and compared with a running model of the start point. A design that loaded the start point on a high grant, or that failed to wrap, would offer the wrong vector.

Preemption runs are also covered. A normal handler is interrupted by the high vector, and the returns must unwind high first, then normal. A design that let a normal line preempt, or that cleared the wrong bit on return, would offer a request while a handler is in service. Acknowledges with no request and lines held through a return check that nothing is granted or cleared by mistake.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVL_NORM = 0;
    localparam int LVL_HI   = 1;
    localparam int NUM_LVL  = 2;
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int N  = 8,
    parameter int VW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [VW-1:0] start,
    output logic          any,
    output logic [VW-1:0] idx
);
    localparam bit POW2 = (N == (1 << VW));

    generate
        if (POW2) begin : g_pow2
            always_comb begin
                any = 1'b0;
                idx = '0;
                for (int k = 0; k < N; k++) begin
                    if (!any && mask[start + VW'(k)]) begin
                        any = 1'b1;
                        idx = start + VW'(k);
                    end
                end
            end
        end else begin : g_mod
            always_comb begin
                any = 1'b0;
                idx = '0;
                for (int k = 0; k < N; k++) begin
                    if (!any && mask[(int'(start) + k) % N]) begin
                        any = 1'b1;
                        idx = VW'((int'(start) + k) % N);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/intc_state.sv
module intc_state
    import intc_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant,
    input  logic          grant_hi,
    input  logic [VW-1:0] grant_vec,
    input  logic          rr_en,
    input  logic          reti,
    output logic [NUM_LVL-1:0] exec_q,
    output logic [VW-1:0] prio_q
);
    typedef struct packed {
        logic [NUM_LVL-1:0] exec;
        logic [VW-1:0]      prio;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reti) begin
            if (s_q.exec[LVL_HI]) s_d.exec[LVL_HI]   = 1'b0;
            else                  s_d.exec[LVL_NORM] = 1'b0;
        end
        if (grant) begin
            if (grant_hi) s_d.exec[LVL_HI] = 1'b1;
            else begin
                s_d.exec[LVL_NORM] = 1'b1;
                if (rr_en) s_d.prio = grant_vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.exec <= '0;
            s_q.prio <= VW'(N - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign exec_q = s_q.exec;
    assign prio_q = s_q.prio;

    // R5
    ack_sets_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> exec_q[$past(grant_hi)]);
    // R7
    reti_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !grant && exec_q[LVL_HI]) |=> (!exec_q[LVL_HI] && exec_q[LVL_NORM] == $past(exec_q[LVL_NORM])));
    // R4
    rr_prio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !grant_hi && rr_en) |=> (prio_q == $past(grant_vec)));
    // R4
    hi_keeps_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_hi) |=> $stable(prio_q));
endmodule

// File: rtl/dual_level_intc.sv
module dual_level_intc
    import intc_pkg::*;
#(
    parameter int          NUM_VEC   = 8,
    parameter int          AW        = 16,
    parameter logic [15:0] BASE_MAIN = 16'h0000,
    parameter logic [15:0] BASE_ALT  = 16'h0200,
    localparam int         VW        = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_lines,
    input  logic               gie,
    input  logic               rr_en,
    input  logic               alt_base,
    input  logic               compact,
    input  logic [VW-1:0]      hi_vec,
    input  logic               ack,
    input  logic               reti,
    output logic               req,
    output logic               req_hi,
    output logic [VW-1:0]      req_vec,
    output logic [AW-1:0]      req_addr,
    output logic [NUM_LVL-1:0] in_service,
    output logic               wake
);
    logic [NUM_VEC-1:0] norm_mask;
    logic [VW-1:0]      prio_q, start, norm_idx;
    logic               norm_any, hi_pend, offer_hi, offer_norm;
    logic [NUM_LVL-1:0] exec_q;
    logic [AW-1:0]      base;

    always_comb begin
        hi_pend    = irq_lines[hi_vec];
        norm_mask  = irq_lines & ~(NUM_VEC'(1) << hi_vec);
        if (!rr_en)                          start = '0;
        else if (prio_q == VW'(NUM_VEC - 1)) start = '0;
        else                                 start = prio_q + VW'(1);
        offer_hi   = gie && hi_pend && !exec_q[LVL_HI];
        offer_norm = gie && norm_any && (exec_q == '0);
        req        = offer_hi || offer_norm;
        req_hi     = offer_hi;
        req_vec    = offer_hi ? hi_vec : norm_idx;
        base       = alt_base ? AW'(BASE_ALT) : AW'(BASE_MAIN);
        if (compact) req_addr = base + (offer_hi ? AW'(2) : AW'(4));
        else         req_addr = base + {{(AW-VW-1){1'b0}}, req_vec, 1'b0};
        wake       = gie && (|irq_lines);
    end

    assign in_service = exec_q;

    intc_pick #(.N(NUM_VEC), .VW(VW)) u_pick (
        .mask  (norm_mask),
        .start (start),
        .any   (norm_any),
        .idx   (norm_idx)
    );

    intc_state #(.N(NUM_VEC), .VW(VW)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (ack && req),
        .grant_hi  (req_hi),
        .grant_vec (req_vec),
        .rr_en     (rr_en),
        .reti      (reti),
        .exec_q    (exec_q),
        .prio_q    (prio_q)
    );

    // R1
    no_req_without_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> gie);
    // R6
    hi_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_service[LVL_HI] |-> !req);
    // R6
    norm_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && in_service[LVL_NORM]) |-> req_hi);
    // R2
    hi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && irq_lines[hi_vec] && !in_service[LVL_HI]) |-> (req && req_vec == hi_vec));
    // R5
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req && !reti) |=> $stable(in_service));
endmodule

// File: tb/dual_level_intc_bench.sv
module dual_level_intc_bench;
    localparam int N = 8;

    logic       clk = 0, rst_n = 0;
    logic [7:0] irq_lines = 0;
    logic       gie = 0, rr_en = 0, alt_base = 0, compact = 0, ack = 0, reti = 0;
    logic [2:0] hi_vec = 0;
    logic       req, req_hi, wake;
    logic [2:0] req_vec;
    logic [15:0] req_addr;
    logic [1:0] in_service;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    dual_level_intc u_dual_level_intc (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .gie(gie), .rr_en(rr_en),
        .alt_base(alt_base), .compact(compact), .hi_vec(hi_vec), .ack(ack), .reti(reti),
        .req(req), .req_hi(req_hi), .req_vec(req_vec), .req_addr(req_addr),
        .in_service(in_service), .wake(wake)
    );

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int pick_from(input logic [7:0] m, input int st);
        for (int k = 0; k < N; k++) if (m[(st + k) % N]) return (st + k) % N;
        return -1;
    endfunction

    task automatic pulse_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0; #1;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0; #1;
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int prio;
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        chk(in_service == 0, "R12 in_service", in_service, 0);
        chk(req == 0, "R12 req", req, 0);
        rst_n = 1;
        @(negedge clk); #1;
        chk(in_service == 0 && req == 0, "R12 after release", {in_service, req}, 0);

        // combinational sweep, fixed order, idle state
        for (int g = 0; g < 2; g++)
        for (int cfg = 0; cfg < 4; cfg++)
        for (int hv = 0; hv < N; hv++)
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            gie = g[0]; alt_base = cfg[0]; compact = cfg[1];
            hi_vec = 3'(hv); irq_lines = 8'(p);
            #1;
            begin
                bit hp; logic [7:0] nm; int ev, base, ea; bit ehi, ereq;
                hp = irq_lines[hv];
                nm = irq_lines & ~(8'd1 << hv);
                ehi = g[0] && hp;
                ereq = g[0] && (p != 0);
                ev = ehi ? hv : pick_from(nm, 0);
                base = cfg[0] ? 'h200 : 'h000;
                ea = cfg[1] ? (base + (ehi ? 2 : 4)) : (base + 2 * ev);
                // R11
                chk(wake == ereq, "R11 wake", wake, ereq);
                if (!g[0]) begin
                    // R1
                    chk(req == 0, "R1 gie off", req, 0);
                end else begin
                    chk(req == ereq, "R2/R3 req", req, ereq);
                    if (ereq) begin
                        // R2 high wins, R3 lowest normal
                        chk(req_hi == ehi && req_vec == 3'(ev), ehi ? "R2 vec" : "R3 vec",
                            {req_hi, req_vec}, {ehi, 3'(ev)});
                        // R9 / R10 address
                        chk(req_addr == 16'(ea), cfg[1] ? "R10 addr" : "R9 addr", req_addr, ea);
                    end
                end
            end
        end

        // R5 ack with no request is ignored
        @(negedge clk); gie = 1; irq_lines = 0; alt_base = 0; compact = 0; rr_en = 0;
        pulse_ack();
        chk(in_service == 0, "R5 idle ack", in_service, 0);

        // R8 pending survives ack and return (fixed order)
        hi_vec = 7; irq_lines = 8'b0001_0100; #1;
        chk(req && req_vec == 2, "R3 pre-ack", req_vec, 2);
        pulse_ack();
        chk(in_service == 2'b01, "R5 normal ack", in_service, 1);
        chk(req == 0, "R6 no normal preempt", req, 0);
        pulse_reti();
        chk(in_service == 0, "R7 normal return", in_service, 0);
        chk(req && req_vec == 2, "R8 still pending", req_vec, 2);

        // R6 preemption by high level, R7 unwinding
        pulse_ack();
        irq_lines = 8'b1001_0100; #1;
        chk(req && req_hi && req_vec == 7, "R6 high preempts", {req_hi, req_vec}, {1'b1, 3'd7});
        pulse_ack();
        chk(in_service == 2'b11, "R5 high ack", in_service, 3);
        chk(req == 0, "R6 high blocks", req, 0);
        pulse_reti();
        chk(in_service == 2'b01, "R7 high cleared first", in_service, 1);
        chk(req && req_hi, "R6 high offered again", req_hi, 1);
        irq_lines = 8'b0001_0100;
        pulse_reti();
        chk(in_service == 0, "R7 normal cleared", in_service, 0);

        // R4 rotating order
        rr_en = 1; prio = N - 1;
        for (int step = 0; step < 24; step++) begin
            logic [7:0] m;
            m = (step < 10) ? 8'h7F : ((step < 17) ? 8'h25 : 8'h48);
            if (step == 20) m = 8'hC0;
            @(negedge clk); irq_lines = m; hi_vec = 7; #1;
            begin
                logic [7:0] nm; int ev; bit ehi;
                nm = m & 8'h7F;
                ehi = m[7];
                ev = ehi ? 7 : pick_from(nm, (prio + 1) % N);
                chk(req && req_vec == 3'(ev), "R4 rotate", req_vec, ev);
                pulse_ack();
                if (!ehi) prio = ev;
                pulse_reti();
                chk(in_service == 0, "R7 rotate return", in_service, 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule